// File: doc/BRIEF.md
# Multidrop Address-Match Receive Filter

This block sits between a serial receiver's character assembler and its receive FIFO on a 9-bit multidrop link. Every received character carries a data byte and a ninth flag that marks it as an address. When automatic address filtering is armed, the block compares each address character with a programmable station address. It keeps its own receiver-enabled state, and it decides for each character whether to drop it or to write it into the FIFO.

A matching address opens the receiver, is stored with its flag in the FIFO's parity-error status slot, and raises a line-status interrupt pulse. Data characters then pass until a foreign address arrives. That address closes the receiver and is not stored. When filtering is not armed, every character passes with the assembler's own parity-error status. The station address register is the same register that holds the second flow-control stop character.

All outputs are registered. A character offered in one cycle produces its FIFO write, status bit and interrupt on the next rising edge.

Top module: `mdrop_addr_filter`

## Requirements
- R1: While reset (rst_n low) is asserted, push_valid, addr_irq, push_status and rx_enabled are all 0 after the next clock edge.
- R2: Filtering is armed only when every bit of cfg_qual is 1. When it is not armed, each valid character is pushed one cycle later with its data, push_status equal to in_perr, and addr_irq 0.
- R3: While armed and rx_enabled is 0, a data character (in_flag=0) or an address character (in_flag=1) whose byte differs from slave_addr is dropped: push_valid stays 0 and rx_enabled stays 0.
- R4: While armed, an address character equal to slave_addr sets rx_enabled. It is pushed with push_status=1 (the flag placed in the parity-error slot).
- R5: Each pushed matching address raises addr_irq for exactly the one cycle of its push. addr_irq is 0 in every other cycle.
- R6: While armed and rx_enabled is 1, data characters are pushed with push_status=0 and rx_enabled is unchanged.
- R7: While armed and rx_enabled is 1, a non-matching address character clears rx_enabled and is not pushed.
- R8: A matching address received while already enabled is pushed again with push_status=1 and keeps rx_enabled at 1.
- R9: When filtering is not armed in a cycle, rx_enabled is 0 after the following edge.
- R10: Results are due one clock after the character is offered. With no valid character, push_valid is 0 and rx_enabled holds, except as R9 requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_qual | input | QUAL_W | Qualification bits; all must be 1 to arm filtering |
| slave_addr | input | DATA_W | Station address (shared with second stop character) |
| in_valid | input | 1 | Received character strobe |
| in_data | input | DATA_W | Received character byte |
| in_flag | input | 1 | Ninth bit: 1 marks an address character |
| in_perr | input | 1 | Parity-error status from the assembler |
| push_valid | output | 1 | FIFO write strobe |
| push_data | output | DATA_W | Byte written to the FIFO |
| push_status | output | 1 | Bit written to the parity-error status slot |
| addr_irq | output | 1 | Line-status interrupt pulse on a matching address |
| rx_enabled | output | 1 | Receiver-enabled state |

## Verification
Every result of this block (FIFO write, status bit, interrupt pulse and the enable state) is due exactly one rising edge after the cycle in which the character or configuration was presented. The bench drives inputs on the falling edge. Its behavioural model advances on each rising edge from the inputs then present, and all five outputs are compared with the model on the next falling edge. A result that arrives a cycle early or late is therefore caught as a mismatch in that cycle. Directed sequences cover each enable transition, and a long pseudo-random stream with a small address space produces frequent matches and mode toggles.

// File: rtl/mdaf_pkg.sv
package mdaf_pkg;
   typedef enum logic [1:0] {
      ACT_DROP      = 2'd0,
      ACT_PUSH      = 2'd1,
      ACT_PUSH_ADDR = 2'd2,
      ACT_PUSH_RAW  = 2'd3
   } mdaf_act_e;
endpackage

// File: rtl/mdaf_qual.sv
module mdaf_qual #(
   parameter int QUAL_W = 3
) (
   input  logic [QUAL_W-1:0] qual,
   output logic              armed
);
   generate
      if (QUAL_W < 1) begin : g_bad_width
         $error("mdaf_qual: QUAL_W must be at least 1");
      end
      if (QUAL_W == 1) begin : g_single
         assign armed = qual[0];
      end else begin : g_multi
         assign armed = &qual;
      end
   endgenerate
endmodule

// File: rtl/mdaf_cmp.sv
module mdaf_cmp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] station,
   input  logic              is_addr,
   output logic              hit
);
   logic [DATA_W-1:0] bit_eq;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign bit_eq[i] = ~(rx_byte[i] ^ station[i]);
      end
   endgenerate

   assign hit = is_addr & (&bit_eq);
endmodule

// File: rtl/mdaf_ctl.sv
module mdaf_ctl
   import mdaf_pkg::*;
(
   input  logic      armed,
   input  logic      valid,
   input  logic      is_addr,
   input  logic      hit,
   input  logic      en_q,
   output mdaf_act_e act,
   output logic      en_d
);
   always_comb begin
      act  = ACT_DROP;
      en_d = en_q;
      if (!armed) begin
         en_d = 1'b0;
         if (valid) act = ACT_PUSH_RAW;
      end else if (valid) begin
         if (hit) begin
            act  = ACT_PUSH_ADDR;
            en_d = 1'b1;
         end else if (is_addr) begin
            act  = ACT_DROP;
            en_d = 1'b0;
         end else if (en_q) begin
            act  = ACT_PUSH;
         end
      end
   end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
   import mdaf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int QUAL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [QUAL_W-1:0] cfg_qual,
   input  logic [DATA_W-1:0] slave_addr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_flag,
   input  logic              in_perr,
   output logic              push_valid,
   output logic [DATA_W-1:0] push_data,
   output logic              push_status,
   output logic              addr_irq,
   output logic              rx_enabled
);
   localparam logic [DATA_W-1:0] DATA_ZERO = '0;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("mdrop_addr_filter: DATA_W must be at least 1");
      end
   endgenerate

   logic      armed;
   logic      hit;
   logic      en_d;
   mdaf_act_e act;

   mdaf_qual #(.QUAL_W(QUAL_W)) u_qual (
      .qual  (cfg_qual),
      .armed (armed)
   );

   mdaf_cmp #(.DATA_W(DATA_W)) u_cmp (
      .rx_byte (in_data),
      .station (slave_addr),
      .is_addr (in_flag),
      .hit     (hit)
   );

   mdaf_ctl u_ctl (
      .armed   (armed),
      .valid   (in_valid),
      .is_addr (in_flag),
      .hit     (hit),
      .en_q    (rx_enabled),
      .act     (act),
      .en_d    (en_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_valid  <= 1'b0;
         push_data   <= DATA_ZERO;
         push_status <= 1'b0;
         addr_irq    <= 1'b0;
         rx_enabled  <= 1'b0;
      end else begin
         rx_enabled <= en_d;
         push_valid <= (act != ACT_DROP);
         addr_irq   <= (act == ACT_PUSH_ADDR);
         if (act != ACT_DROP) begin
            push_data <= in_data;
         end
         unique case (act)
            ACT_PUSH_RAW:  push_status <= in_perr;
            ACT_PUSH_ADDR: push_status <= 1'b1;
            ACT_PUSH:      push_status <= 1'b0;
            default:       push_status <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
   parameter int DATA_W = 8,
   parameter int QUAL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [QUAL_W-1:0] cfg_qual,
   input logic [DATA_W-1:0] slave_addr,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              in_flag,
   input logic              in_perr,
   input logic              push_valid,
   input logic [DATA_W-1:0] push_data,
   input logic              push_status,
   input logic              addr_irq,
   input logic              rx_enabled
);
   logic is_armed;
   logic is_match;
   assign is_armed = &cfg_qual;
   assign is_match = in_flag && (in_data == slave_addr);

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!push_valid && !addr_irq && !push_status && !rx_enabled));

   a_r2_bypass_push: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_armed && in_valid) |=>
         (push_valid && push_data == $past(in_data) && push_status == $past(in_perr) && !addr_irq));

   a_r3_drop_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (is_armed && !rx_enabled && in_valid && !is_match) |=> (!push_valid && !rx_enabled));

   a_r4_match_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (is_armed && in_valid && is_match) |=> (rx_enabled && push_valid && push_status));

   a_r5_irq_with_push: assert property (@(posedge clk) disable iff (!rst_n)
      addr_irq |-> (push_valid && push_status));

   a_r7_foreign_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (is_armed && rx_enabled && in_valid && in_flag && !is_match) |=> (!rx_enabled && !push_valid));

   a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !is_armed |=> !rx_enabled);

   a_r10_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && is_armed) |=> (!push_valid && rx_enabled == $past(rx_enabled)));
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W), .QUAL_W(QUAL_W)) u_chk (.*);

// File: tb/mdrop_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb_top;
   localparam int DW = 8;
   localparam int QW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [QW-1:0] cfg_qual = '0;
   logic [DW-1:0] slave_addr = 8'h5A;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_flag = 1'b0;
   logic          in_perr = 1'b0;
   logic          push_valid;
   logic [DW-1:0] push_data;
   logic          push_status;
   logic          addr_irq;
   logic          rx_enabled;

   always #4 clk = ~clk;

   mdrop_addr_filter #(.DATA_W(DW), .QUAL_W(QW)) dut_i (.*);

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // behavioural model state
   bit       m_pv, m_st, m_irq, m_en;
   bit [7:0] m_data;

   task automatic model_edge();
      bit armed, match;
      armed = (cfg_qual == 3'b111);
      match = in_flag && (in_data == slave_addr);
      if (!rst_n) begin
         m_pv = 0; m_st = 0; m_irq = 0; m_en = 0; m_data = 0;
         return;
      end
      m_pv = 0; m_irq = 0;
      if (!armed) begin
         m_en = 0;
         if (in_valid) begin m_pv = 1; m_data = in_data; m_st = in_perr; end
      end else if (in_valid) begin
         if (match) begin
            m_en = 1; m_pv = 1; m_data = in_data; m_st = 1; m_irq = 1;
         end else if (in_flag) begin
            m_en = 0;
         end else if (m_en) begin
            m_pv = 1; m_data = in_data; m_st = 0;
         end
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      cycles++;
      @(negedge clk);
      total++;
      if (push_valid !== m_pv || addr_irq !== m_irq || rx_enabled !== m_en ||
          (m_pv && (push_data !== m_data || push_status !== m_st)) ||
          (!rst_n && push_status !== 1'b0)) begin
         bad++;
         $display("FAIL %s: got pv=%0b d=%02h st=%0b irq=%0b en=%0b exp pv=%0b d=%02h st=%0b irq=%0b en=%0b",
                  tag, push_valid, push_data, push_status, addr_irq, rx_enabled,
                  m_pv, m_data, m_st, m_irq, m_en);
      end
   endtask

   task automatic chr(input bit flag, input bit [7:0] d, input bit perr, input string tag);
      in_valid = 1; in_flag = flag; in_data = d; in_perr = perr;
      step(tag);
      in_valid = 0; in_flag = 0; in_perr = 0;
   endtask

   initial begin : watchdog
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      step("R1"); step("R1");
      rst_n = 1;
      // R2: not armed, pass-through with parity status
      cfg_qual = 3'b011;
      chr(0, 8'h11, 1, "R2");
      chr(1, 8'h5A, 0, "R2");
      cfg_qual = 3'b101;
      chr(1, 8'h22, 1, "R2");
      cfg_qual = 3'b110;
      chr(0, 8'h33, 0, "R2");
      // arm
      cfg_qual = 3'b111;
      step("R10");
      chr(0, 8'h44, 1, "R3");          // data while closed
      chr(1, 8'h5B, 0, "R3");          // foreign address while closed
      chr(1, 8'h5A, 0, "R4 R5");       // match opens
      step("R10");                     // idle holds enable
      chr(0, 8'h66, 1, "R6");
      chr(0, 8'h67, 0, "R6");
      chr(1, 8'h5A, 0, "R8");          // match while open
      chr(0, 8'h68, 0, "R6");
      chr(1, 8'hA5, 0, "R7");          // foreign closes
      chr(0, 8'h69, 0, "R3");          // now dropped
      chr(1, 8'h5A, 0, "R4");
      slave_addr = 8'hC3;
      chr(1, 8'h5A, 0, "R7");
      chr(1, 8'hC3, 0, "R4 R5");
      cfg_qual = 3'b011;
      step("R9");
      cfg_qual = 3'b111;
      chr(0, 8'h70, 0, "R9 R3");
      // mixed stream
      slave_addr = 8'h02;
      for (int i = 0; i < 3000; i++) begin
         bit [31:0] r;
         r = $urandom;
         cfg_qual   = (r[3:0] == 4'h0) ? 3'b110 : 3'b111;
         in_valid   = r[4] | r[5];
         in_flag    = r[6] & r[7];
         in_data    = {6'b0, r[9:8]};
         in_perr    = r[10];
         if (r[15:11] == 5'h0) rst_n = 0;
         step("R10");
         rst_n = 1;
      end
      in_valid = 0;
      step("R10");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule